// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits after pre-decode in a two-pipe in-order front end. Each cycle it is offered the next two instructions in program order: the older one is the candidate for the U-pipe, the younger one for the V-pipe. It decides whether both can issue together or whether only the older one goes. Each instruction arrives as a packed descriptor. The descriptor carries the class (integer, SIMD, floating point), the pipe category, the length in bytes, integer register references with a sub-register part, a flags-write bit, SIMD register references, SIMD unit use, a SIMD memory or integer-file access bit, a state-clear bit, a branch bit and a first-SIMD-after-FP bit.

The decision is registered and appears one clock after the offer. When the pair is refused, only the older instruction issues. The front end then offers the refused instruction again next cycle as the new U candidate. A one-hot reason code names the single rule that blocked the pair, picked by a fixed priority. A separate output tells the flags logic that the V instruction supplies the final condition flags.

Top module: `pair_issue_checker`

## Requirements
- R1: After reset, res_vld_o, pair_o, reason_o and v_flags_o are all 0. An offer with the U descriptor valid bit set at a rising edge gives res_vld_o=1 with its decision during the following clock. Offers on back-to-back cycles each give their own result, and cycles without a valid U descriptor give res_vld_o=0.
- R2: When res_vld_o=1, reason_o is zero exactly when pair_o=1. Otherwise reason_o has one bit set: the lowest-numbered violated rule in this order: bit0 no partner, bit1 category, bit2 U branch, bit3 V length, bit4 class mix, bit5 V SIMD port, bit6 SIMD unit, bit7 SIMD register, bit8 integer flow, bit9 integer output.
- R3: A valid U descriptor with an invalid V descriptor gives no pair with reason bit0. With the U descriptor invalid, no result is produced, whatever the V descriptor holds.
- R4: Category codes are 0 either pipe, 1 U only, 2 V only, 3 never. The pair is refused with bit1 unless U has code 0 or 1 and V has code 0 or 2.
- R5: A branch in the U slot refuses the pair with bit2.
- R6: A V instruction longer than 7 bytes refuses the pair with bit3. Exactly 7 bytes is allowed.
- R7: Bit4 refuses the pair in three cases: a floating-point instruction together with a SIMD instruction, either instruction being the SIMD state-clear, or a V-slot SIMD instruction marked first SIMD after floating point.
- R8: A V-slot SIMD instruction that accesses memory or the integer register file refuses the pair with bit5. The same access in the U slot does not block.
- R9: Two SIMD instructions that both use the shifter, or both use the multiplier, refuse the pair with bit6. One shifter user paired with one multiplier user is allowed.
- R10: Between two SIMD instructions, a valid U SIMD destination equal to the V SIMD destination or to any valid V SIMD source refuses the pair with bit7. A V destination equal to a U source does not block.
- R11: A valid U integer destination whose register index equals that of any valid V integer source refuses the pair with bit8. The part field (0 low byte, 1 high byte, 2 word, 3 full) is ignored.
- R12: Valid U and V integer destinations with the same index refuse the pair with bit9, regardless of part. A V write to a register the U instruction only reads does not block, and both writing the flags does not block.
- R13: v_flags_o is 1 only when the pair issues and the V instruction writes the flags. It is 0 when the pair is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| u_insn_i | input | INSN_W (46) | Older instruction descriptor, U-pipe candidate |
| v_insn_i | input | INSN_W (46) | Younger instruction descriptor, V-pipe candidate |
| res_vld_o | output | 1 | Decision valid |
| pair_o | output | 1 | Both instructions issue |
| reason_o | output | RSN_N (10) | One-hot blocking rule, zero when paired |
| v_flags_o | output | 1 | Final flags come from the V instruction |

## Verification
Each blocking rule is paired with a nearby pattern that must still pair, so each check separates the rule from a too-broad version of it:
- length 7 against length 8
- shifter plus multiplier against shifter plus shifter
- anti-dependence against flow dependence
- flags-only common destination against a shared register

Low-byte and high-byte writes to one register, and a low-byte write read as the full register, show that the part field is ignored. Pairs that break several rules at once check the priority order. A refused instruction is re-offered as the U candidate in the next cycle to exercise back-to-back decisions.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;

  parameter int IREG_N    = 8;
  parameter int SREG_N    = 8;
  parameter int NSRC      = 2;
  parameter int LEN_W     = 4;
  parameter int MAX_V_LEN = 7;

  localparam int IREG_W = $clog2(IREG_N);
  localparam int SREG_W = $clog2(SREG_N);

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_SIMD = 2'd1,
    CLS_FP   = 2'd2,
    CLS_RSVD = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    CAT_UV = 2'd0,
    CAT_PU = 2'd1,
    CAT_PV = 2'd2,
    CAT_NP = 2'd3
  } cat_e;

  typedef enum logic [1:0] {
    PART_LO = 2'd0,
    PART_HI = 2'd1,
    PART_W  = 2'd2,
    PART_D  = 2'd3
  } part_e;

  typedef struct packed {
    logic              vld;
    logic [IREG_W-1:0] idx;
    part_e             part;
  } ireg_t;

  typedef struct packed {
    logic              vld;
    logic [SREG_W-1:0] idx;
  } sreg_t;

  typedef struct packed {
    logic                  vld;
    cls_e                  cls;
    cat_e                  cat;
    logic [LEN_W-1:0]      len;
    logic                  branch;
    logic                  sclr;
    ireg_t                 idst;
    ireg_t [NSRC-1:0]      isrc;
    logic                  flg_wr;
    sreg_t                 sdst;
    sreg_t [NSRC-1:0]      ssrc;
    logic                  shf;
    logic                  mul;
    logic                  port;
    logic                  after_fp;
  } insn_t;

  localparam int INSN_W = $bits(insn_t);

  // Reason bit positions, lowest index has highest priority
  localparam int RSN_PARTNER = 0;
  localparam int RSN_CAT     = 1;
  localparam int RSN_BRANCH  = 2;
  localparam int RSN_LEN     = 3;
  localparam int RSN_MIX     = 4;
  localparam int RSN_PORT    = 5;
  localparam int RSN_UNIT    = 6;
  localparam int RSN_SDEP    = 7;
  localparam int RSN_FLOW    = 8;
  localparam int RSN_OUT     = 9;
  localparam int RSN_N       = 10;

endpackage

// File: rtl/pair_slot_rules.sv
module pair_slot_rules
  import pairchk_pkg::*;
#(
  parameter int LW   = LEN_W,
  parameter int VMAX = MAX_V_LEN
) (
  input  logic          v_vld,
  input  cat_e          u_cat,
  input  cat_e          v_cat,
  input  logic          u_branch,
  input  logic [LW-1:0] v_len,
  output logic          viol_partner,
  output logic          viol_cat,
  output logic          viol_branch,
  output logic          viol_len
);

  localparam logic [LW-1:0] VMAX_L = LW'(VMAX);

  logic u_ok;
  logic v_ok;

  always_comb begin
    u_ok = (u_cat == CAT_UV) || (u_cat == CAT_PU);
    v_ok = (v_cat == CAT_UV) || (v_cat == CAT_PV);
    viol_partner = !v_vld;
    viol_cat     = !(u_ok && v_ok);
    // a U-slot branch may redirect, so its successor cannot ride along
    viol_branch  = u_branch;
    viol_len     = (v_len > VMAX_L);
  end

endmodule

// File: rtl/pair_simd_rules.sv
module pair_simd_rules
  import pairchk_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int SW = SREG_W
) (
  input  cls_e             u_cls,
  input  cls_e             v_cls,
  input  logic             u_sclr,
  input  logic             v_sclr,
  input  logic             v_after_fp,
  input  logic             u_shf,
  input  logic             u_mul,
  input  logic             v_shf,
  input  logic             v_mul,
  input  logic             v_port,
  input  logic             u_dst_vld,
  input  logic [SW-1:0]    u_dst_idx,
  input  logic             v_dst_vld,
  input  logic [SW-1:0]    v_dst_idx,
  input  logic [NS-1:0]    v_src_vld,
  input  logic [NS*SW-1:0] v_src_idx,
  output logic             viol_mix,
  output logic             viol_port,
  output logic             viol_unit,
  output logic             viol_sdep
);

  logic          u_simd;
  logic          v_simd;
  logic          both_simd;
  logic [NS-1:0] src_hit;

  assign u_simd    = (u_cls == CLS_SIMD);
  assign v_simd    = (v_cls == CLS_SIMD);
  assign both_simd = u_simd && v_simd;

  // per-source match of U SIMD destination against V SIMD sources
  for (genvar s = 0; s < NS; s++) begin : g_src
    assign src_hit[s] = v_src_vld[s] && (v_src_idx[s*SW +: SW] == u_dst_idx);
  end

  always_comb begin
    viol_mix = ((u_cls == CLS_FP) && v_simd) ||
               (u_simd && (v_cls == CLS_FP)) ||
               u_sclr || v_sclr ||
               (v_simd && v_after_fp);
    viol_port = v_simd && v_port;
    viol_unit = both_simd && ((u_shf && v_shf) || (u_mul && v_mul));
    viol_sdep = both_simd && u_dst_vld &&
                ((v_dst_vld && (v_dst_idx == u_dst_idx)) || (|src_hit));
  end

endmodule

// File: rtl/pair_int_hazard.sv
module pair_int_hazard
  import pairchk_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int IW = IREG_W
) (
  input  logic             u_dst_vld,
  input  logic [IW-1:0]    u_dst_idx,
  input  logic             v_dst_vld,
  input  logic [IW-1:0]    v_dst_idx,
  input  logic [NS-1:0]    v_src_vld,
  input  logic [NS*IW-1:0] v_src_idx,
  output logic             viol_flow,
  output logic             viol_out
);

  // Only whole-register indices reach this module: byte and word parts
  // collapse onto their containing register for contention.
  logic [NS-1:0] rd_hit;

  for (genvar s = 0; s < NS; s++) begin : g_rd
    assign rd_hit[s] = v_src_vld[s] && (v_src_idx[s*IW +: IW] == u_dst_idx);
  end

  always_comb begin
    viol_flow = u_dst_vld && (|rd_hit);
    viol_out  = u_dst_vld && v_dst_vld && (u_dst_idx == v_dst_idx);
  end

endmodule

// File: rtl/pair_issue_checker.sv
module pair_issue_checker
  import pairchk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSN_W-1:0] u_insn_i,
  input  logic [INSN_W-1:0] v_insn_i,
  output logic              res_vld_o,
  output logic              pair_o,
  output logic [RSN_N-1:0]  reason_o,
  output logic              v_flags_o
);

  insn_t u_in;
  insn_t v_in;
  assign u_in = insn_t'(u_insn_i);
  assign v_in = insn_t'(v_insn_i);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // ---------------- field extraction ----------------
  logic [NSRC-1:0]        isrc_vld;
  logic [NSRC*IREG_W-1:0] isrc_idx;
  logic [NSRC-1:0]        ssrc_vld;
  logic [NSRC*SREG_W-1:0] ssrc_idx;

  for (genvar s = 0; s < NSRC; s++) begin : g_fld
    assign isrc_vld[s]                   = v_in.isrc[s].vld;
    assign isrc_idx[s*IREG_W +: IREG_W]  = v_in.isrc[s].idx;
    assign ssrc_vld[s]                   = v_in.ssrc[s].vld;
    assign ssrc_idx[s*SREG_W +: SREG_W]  = v_in.ssrc[s].idx;
  end

  // fields that no rule consults (U sources, parts, U length, ...)
  logic unused_fields;
  assign unused_fields = ^{u_in, v_in};

  // ---------------- rule groups ----------------
  logic [RSN_N-1:0] viol;

  pair_slot_rules #(.LW(LEN_W), .VMAX(MAX_V_LEN)) i_slot (
    .v_vld        (v_in.vld),
    .u_cat        (u_in.cat),
    .v_cat        (v_in.cat),
    .u_branch     (u_in.branch),
    .v_len        (v_in.len),
    .viol_partner (viol[RSN_PARTNER]),
    .viol_cat     (viol[RSN_CAT]),
    .viol_branch  (viol[RSN_BRANCH]),
    .viol_len     (viol[RSN_LEN])
  );

  pair_simd_rules #(.NS(NSRC), .SW(SREG_W)) i_simd (
    .u_cls      (u_in.cls),
    .v_cls      (v_in.cls),
    .u_sclr     (u_in.sclr),
    .v_sclr     (v_in.sclr),
    .v_after_fp (v_in.after_fp),
    .u_shf      (u_in.shf),
    .u_mul      (u_in.mul),
    .v_shf      (v_in.shf),
    .v_mul      (v_in.mul),
    .v_port     (v_in.port),
    .u_dst_vld  (u_in.sdst.vld),
    .u_dst_idx  (u_in.sdst.idx),
    .v_dst_vld  (v_in.sdst.vld),
    .v_dst_idx  (v_in.sdst.idx),
    .v_src_vld  (ssrc_vld),
    .v_src_idx  (ssrc_idx),
    .viol_mix   (viol[RSN_MIX]),
    .viol_port  (viol[RSN_PORT]),
    .viol_unit  (viol[RSN_UNIT]),
    .viol_sdep  (viol[RSN_SDEP])
  );

  pair_int_hazard #(.NS(NSRC), .IW(IREG_W)) i_int (
    .u_dst_vld (u_in.idst.vld),
    .u_dst_idx (u_in.idst.idx),
    .v_dst_vld (v_in.idst.vld),
    .v_dst_idx (v_in.idst.idx),
    .v_src_vld (isrc_vld),
    .v_src_idx (isrc_idx),
    .viol_flow (viol[RSN_FLOW]),
    .viol_out  (viol[RSN_OUT])
  );

  // ---------------- next state ----------------
  logic [RSN_N-1:0] rsn_n;
  logic             pair_n;
  logic             flg_n;

  always_comb begin
    logic taken;
    rsn_n = '0;
    taken = 1'b0;
    for (int i = 0; i < RSN_N; i++) begin
      if (viol[i] && !taken) begin
        rsn_n[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    pair_n = !taken;
    // on a pair both may write flags; the V result is the one that lands
    flg_n  = pair_n && v_in.flg_wr;
  end

  // ---------------- registers ----------------
  logic             vld_q;
  logic             pair_q;
  logic [RSN_N-1:0] rsn_q;
  logic             flg_q;
  logic             dec_en;

  assign dec_en = u_in.vld;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q  <= 1'b0;
      pair_q <= 1'b0;
      rsn_q  <= '0;
      flg_q  <= 1'b0;
    end else begin
      vld_q <= dec_en;
      if (dec_en) begin
        pair_q <= pair_n;
        rsn_q  <= rsn_n;
        flg_q  <= flg_n;
      end else begin
        pair_q <= 1'b0;
        flg_q  <= 1'b0;
      end
    end
  end

  assign res_vld_o = vld_q;
  assign pair_o    = pair_q;
  assign reason_o  = rsn_q;
  assign v_flags_o = flg_q;

  // ---------------- assertions ----------------
  a_r1_result_follows_offer: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    u_in.vld |=> res_vld_o);

  a_r1_no_offer_no_result: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !u_in.vld |=> !res_vld_o);

  a_r2_reason_onehot: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    res_vld_o |-> ($onehot0(reason_o) && (pair_o == (reason_o == '0))));

  a_r5_branch_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (u_in.vld && u_in.branch) |=> (res_vld_o && !pair_o));

  a_r6_long_v_blocks: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (u_in.vld && v_in.vld && (v_in.len > LEN_W'(MAX_V_LEN))) |=> !pair_o);

  a_r7_state_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (u_in.vld && (u_in.sclr || v_in.sclr)) |=> !pair_o);

  a_r13_flags_only_on_pair: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !pair_o |-> !v_flags_o);

endmodule

// File: tb/test_pair_issue_checker.sv
module test_pair_issue_checker;
  import pairchk_pkg::*;

  logic              clk;
  logic              rst_n;
  insn_t             u_drv;
  insn_t             v_drv;
  logic              res_vld;
  logic              pair;
  logic [RSN_N-1:0]  reason;
  logic              vflags;

  pair_issue_checker i_pair_issue_checker (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .u_insn_i  (u_drv),
    .v_insn_i  (v_drv),
    .res_vld_o (res_vld),
    .pair_o    (pair),
    .reason_o  (reason),
    .v_flags_o (vflags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic             pair;
    logic [RSN_N-1:0] rsn;
    logic             flg;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic mon_on   = 1'b0;
  logic done     = 1'b0;

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // ---------------- descriptor helpers ----------------
  function automatic insn_t blank();
    insn_t x;
    x      = '0;
    x.vld  = 1'b1;
    x.cls  = CLS_INT;
    x.cat  = CAT_UV;
    x.len  = LEN_W'(2);
    return x;
  endfunction

  function automatic ireg_t ir(int idx, part_e p);
    ireg_t r;
    r.vld  = 1'b1;
    r.idx  = IREG_W'(idx);
    r.part = p;
    return r;
  endfunction

  function automatic sreg_t sr(int idx);
    sreg_t r;
    r.vld = 1'b1;
    r.idx = SREG_W'(idx);
    return r;
  endfunction

  function automatic insn_t simd();
    insn_t x;
    x     = blank();
    x.cls = CLS_SIMD;
    return x;
  endfunction

  // ---------------- driver ----------------
  task automatic offer(insn_t u, insn_t v, logic ep, int ebit, logic ef, string tag);
    exp_t e;
    @(negedge clk);
    u_drv = u;
    v_drv = v;
    e.pair = ep;
    e.rsn  = (ebit < 0) ? '0 : (RSN_N'(1) << ebit);
    e.flg  = ef;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (mon_on && res_vld) begin
      exp_t e;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R1 unexpected result: pair=%0b reason=%b expected none", pair, reason);
      end else begin
        e = exp_q.pop_front();
        if (pair !== e.pair || reason !== e.rsn || vflags !== e.flg) begin
          n_errors++;
          $display("FAIL %s: pair=%0b reason=%b flags=%0b expected pair=%0b reason=%b flags=%0b",
                   e.tag, pair, reason, vflags, e.pair, e.rsn, e.flg);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    insn_t u;
    insn_t v;
    u_drv = '0;
    v_drv = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    n_checks++;
    if (res_vld !== 1'b0 || pair !== 1'b0 || reason !== '0 || vflags !== 1'b0) begin
      n_errors++;
      $display("FAIL R1 reset: vld=%0b pair=%0b reason=%b flags=%0b expected all 0",
               res_vld, pair, reason, vflags);
    end
    mon_on = 1'b1;

    // R1/R2 basic independent integer pair
    u = blank(); u.idst = ir(0, PART_D); u.isrc[0] = ir(1, PART_D);
    v = blank(); v.idst = ir(2, PART_D); v.isrc[0] = ir(3, PART_D);
    offer(u, v, 1, -1, 0, "R1 independent pair");

    // R13/R12: both write flags, pair, V flags win
    u = blank(); u.idst = ir(0, PART_D); u.flg_wr = 1;
    v = blank(); v.idst = ir(2, PART_D); v.flg_wr = 1;
    offer(u, v, 1, -1, 1, "R13 flags from V");

    // R13: only U writes flags
    v.flg_wr = 0;
    offer(u, v, 1, -1, 0, "R13 U-only flags");

    // R3: no partner
    u = blank(); v = blank(); v.vld = 0;
    offer(u, v, 0, RSN_PARTNER, 0, "R3 missing V");

    // R4: categories
    u = blank(); u.cat = CAT_PV; v = blank();
    offer(u, v, 0, RSN_CAT, 0, "R4 V-only in U");
    u = blank(); v = blank(); v.cat = CAT_PU;
    offer(u, v, 0, RSN_CAT, 0, "R4 U-only in V");
    u = blank(); u.cat = CAT_NP; v = blank();
    offer(u, v, 0, RSN_CAT, 0, "R4 never-pair");
    u = blank(); u.cat = CAT_PU; v = blank(); v.cat = CAT_PV;
    offer(u, v, 1, -1, 0, "R4 U-only with V-only");

    // R5: branch in U
    u = blank(); u.branch = 1; v = blank();
    offer(u, v, 0, RSN_BRANCH, 0, "R5 U branch");

    // R6: length limit
    u = blank(); v = blank(); v.len = LEN_W'(7);
    offer(u, v, 1, -1, 0, "R6 length 7");
    v.len = LEN_W'(8);
    offer(u, v, 0, RSN_LEN, 0, "R6 length 8");
    // refused V re-offered as U candidate next cycle (R1 back-to-back)
    u = v; v = blank();
    offer(u, v, 1, -1, 0, "R1 re-offer as U");

    // R7: class mix
    u = blank(); u.cls = CLS_FP; v = simd();
    offer(u, v, 0, RSN_MIX, 0, "R7 FP with SIMD");
    u = simd(); u.sclr = 1; v = blank();
    offer(u, v, 0, RSN_MIX, 0, "R7 state clear");
    u = blank(); v = simd(); v.after_fp = 1;
    offer(u, v, 0, RSN_MIX, 0, "R7 first SIMD after FP in V");
    v.after_fp = 0;
    offer(u, v, 1, -1, 0, "R7 int with SIMD");

    // R8: SIMD port
    u = blank(); v = simd(); v.port = 1;
    offer(u, v, 0, RSN_PORT, 0, "R8 V SIMD port");
    u = simd(); u.port = 1; v = simd();
    offer(u, v, 1, -1, 0, "R8 U SIMD port");

    // R9: units
    u = simd(); u.shf = 1; v = simd(); v.shf = 1;
    offer(u, v, 0, RSN_UNIT, 0, "R9 two shifts");
    u = simd(); u.mul = 1; v = simd(); v.mul = 1;
    offer(u, v, 0, RSN_UNIT, 0, "R9 two multiplies");
    u = simd(); u.shf = 1; v = simd(); v.mul = 1;
    offer(u, v, 1, -1, 0, "R9 shift with multiply");

    // R10: SIMD register dependency
    u = simd(); u.sdst = sr(3); v = simd(); v.sdst = sr(5); v.ssrc[1] = sr(3);
    offer(u, v, 0, RSN_SDEP, 0, "R10 U dst feeds V src");
    u = simd(); u.sdst = sr(3); v = simd(); v.sdst = sr(3);
    offer(u, v, 0, RSN_SDEP, 0, "R10 same SIMD dst");
    u = simd(); u.sdst = sr(2); u.ssrc[0] = sr(4); v = simd(); v.sdst = sr(4);
    offer(u, v, 1, -1, 0, "R10 SIMD anti dependence");

    // R11: integer flow, part folded
    u = blank(); u.idst = ir(0, PART_LO); v = blank(); v.isrc[1] = ir(0, PART_D);
    offer(u, v, 0, RSN_FLOW, 0, "R11 low byte read as full");

    // R12: output dependence and exceptions
    u = blank(); u.idst = ir(0, PART_LO); v = blank(); v.idst = ir(0, PART_HI);
    offer(u, v, 0, RSN_OUT, 0, "R12 low and high byte writes");
    u = blank(); u.idst = ir(1, PART_D); u.isrc[0] = ir(5, PART_D);
    v = blank(); v.idst = ir(5, PART_W);
    offer(u, v, 1, -1, 0, "R12 anti dependence");

    // R13: flags with refused pair
    u = blank(); u.idst = ir(6, PART_D); u.flg_wr = 1;
    v = blank(); v.isrc[0] = ir(6, PART_D); v.flg_wr = 1;
    offer(u, v, 0, RSN_FLOW, 0, "R13 flags on refused pair");

    // R2: priority between simultaneous violations
    u = blank(); u.branch = 1; u.idst = ir(2, PART_D);
    v = blank(); v.isrc[0] = ir(2, PART_D);
    offer(u, v, 0, RSN_BRANCH, 0, "R2 branch over flow");
    u = blank(); u.idst = ir(4, PART_D);
    v = blank(); v.idst = ir(4, PART_D); v.len = LEN_W'(9);
    offer(u, v, 0, RSN_LEN, 0, "R2 length over output");
    u = simd(); u.shf = 1; u.sdst = sr(1);
    v = simd(); v.shf = 1; v.sdst = sr(1); v.port = 1;
    offer(u, v, 0, RSN_PORT, 0, "R2 port over unit and register");

    // R3: U invalid, V valid -> no result
    @(negedge clk);
    u_drv = '0;
    v_drv = blank();
    repeat (2) @(negedge clk);
    n_checks++;
    if (res_vld !== 1'b0) begin
      n_errors++;
      $display("FAIL R3 invalid U: res_vld=%0b expected 0", res_vld);
    end
    repeat (2) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL R1 missing results: pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end

endmodule